// File: doc/BRIEF.md
# Power-Management Timer with Relocatable Byte Window

This block keeps a free-running count of timer ticks. A clock divider outside the block supplies a one-cycle `tick_en` pulse at 3.579545 MHz, and the count steps once per pulse. Software reads the count one byte at a time through a 256-byte I/O window. Two configuration bytes set where that window sits and whether it answers. The count register is always `CNT_W` bits wide (32 by default). A width bit in the control byte picks what software sees: the full count, or only the low `NARROW_W` bits (24 by default), with every higher bit read as zero.

A configuration write port loads the control byte at address 0x41 and the window-base byte at address 0x49. Bit 7 of the control byte opens the window and bit 3 selects the wide view. Every other configuration address is ignored. The window starts at the base byte shifted left by eight. It decodes only while it is open and the base is nonzero. Inside the window, offsets 0x08 upward hold the count lanes, least significant byte first. Every other offset reads 0xFF.

A read of lane 0 also captures the visible count in a snapshot register, so the higher lanes of one multi-byte read all come from the same instant. A small state machine has two states, `SNAP_IDLE` and `SNAP_HELD`, and four transitions:

- IDLE to HELD on a lane-0 read.
- HELD to HELD on a lane-0 read, which reloads the snapshot.
- HELD to IDLE on a read of the last lane.
- Any other read leaves the state unchanged.

While the state is HELD, lanes above 0 return snapshot bytes. While it is IDLE, they return live bytes.

Top module: `pm_timer_top`

## Requirements
- R1: After reset, the count is zero, the window is closed, the base is zero and the narrow view is selected, so no read hits until the window is configured.
- R2: The count steps by exactly one on each clock edge where `tick_en` is high and holds otherwise. It wraps modulo 2^CNT_W.
- R3: A read hits only when control bit 7 is set, the base byte is nonzero, and `io_addr[15:8]` equals the base byte.
- R4: A hit at offset 0x08 returns bits 7:0 of the visible count. Lane k sits at offset 0x08+k, for k from 0 to CNT_W/8-1.
- R5: With control bit 3 clear, count bits at or above NARROW_W read as zero in every lane.
- R6: With control bit 3 set, every lane shows the full count.
- R7: A hit at any offset outside the timer lanes returns 0xFF.
- R8: Configuration writes to addresses other than 0x41 and 0x49 change nothing that a later window read could show.
- R9: A lane-0 read captures the visible count. Later reads of lanes above 0 return the captured bytes until the last lane has been read. After that, those lanes return live bytes again.
- R10: `io_hit` and `io_rdata` are registered. They are valid in the cycle after `io_rd` and last for one cycle. `io_rdata` is 0x00 whenever `io_hit` is low.
- R11: A configuration write takes effect for a read issued in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the timer rate |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| io_addr | input | 16 | I/O read address |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Read data, valid with io_hit |
| io_hit | output | 1 | The read one cycle earlier decoded inside the window |

## Verification
The bench builds the block with CNT_W=16 and NARROW_W=8, so the count has two byte lanes. This lets a few hundred ticks drive a nonzero high byte, which makes the narrow-view masking and the snapshot carry across lanes observable. A full wrap of the count takes 65,536 ticks, which also fits in a short run. The default build of 32 and 24 uses the same lane mux, built by generate, with four lanes instead of two.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;
    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;

    localparam logic [7:0] CFG_CTRL_ADDR = 8'h41;
    localparam logic [7:0] CFG_BASE_ADDR = 8'h49;
    localparam int         CTRL_EN_BIT   = 7;
    localparam int         CTRL_WIDE_BIT = 3;
    localparam logic [7:0] TIMER_OFS     = 8'h08;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       win_en,
    output logic       wide,
    output logic [7:0] base
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en <= 1'b0;
            wide   <= 1'b0;
            base   <= 8'h00;
        end else if (we) begin
            if (addr == CFG_CTRL_ADDR) begin
                win_en <= wdata[CTRL_EN_BIT];
                wide   <= wdata[CTRL_WIDE_BIT];
            end
            if (addr == CFG_BASE_ADDR) begin
                base <= wdata;
            end
        end
    end
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pm_snap_fsm.sv
module pm_snap_fsm
    import pm_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_lane0,
    input  logic             rd_last,
    input  logic [CNT_W-1:0] live_val,
    output logic             held,
    output logic [CNT_W-1:0] snap
);
    snap_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SNAP_IDLE;
            snap    <= '0;
        end else begin
            state_q <= state_d;
            if (rd_lane0) begin
                snap <= live_val;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE: if (rd_lane0) state_d = SNAP_HELD;
            SNAP_HELD: begin
                if (rd_lane0)     state_d = SNAP_HELD;
                else if (rd_last) state_d = SNAP_IDLE;
            end
            default:   state_d = SNAP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        held = (state_q == SNAP_HELD);
    end
endmodule

// File: rtl/pm_timer_top.sv
module pm_timer_top
    import pm_timer_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    output logic [7:0]  io_rdata,
    output logic        io_hit
);
    localparam int LANES  = CNT_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam logic [7:0] LAST_OFS = 8'(TIMER_OFS + LANES - 1);
    localparam logic [CNT_W-1:0] NARROW_MASK =
        {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic             win_en, wide;
    logic [7:0]       win_base;
    logic [CNT_W-1:0] cnt_q, vis_val, snap_val, src_val;
    logic             held;
    logic             rd_hit, in_timer, is_lane0, rd_lane0, rd_last;
    logic [LANE_W-1:0] lane_sel;
    logic [7:0]       lane_b [LANES];
    logic [7:0]       rd_byte;

    pm_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .win_en (win_en),
        .wide   (wide),
        .base   (win_base)
    );

    pm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt     (cnt_q)
    );

    always_comb begin
        rd_hit   = io_rd && win_en && (win_base != 8'h00) &&
                   (io_addr[15:8] == win_base);
        in_timer = (io_addr[7:0] >= TIMER_OFS) && (io_addr[7:0] <= LAST_OFS);
        is_lane0 = (io_addr[7:0] == TIMER_OFS);
        rd_lane0 = rd_hit && is_lane0;
        rd_last  = rd_hit && (io_addr[7:0] == LAST_OFS);
        lane_sel = LANE_W'(io_addr[7:0] - TIMER_OFS);
        vis_val  = wide ? cnt_q : (cnt_q & NARROW_MASK);
    end

    pm_snap_fsm #(.CNT_W(CNT_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lane0 (rd_lane0),
        .rd_last  (rd_last),
        .live_val (vis_val),
        .held     (held),
        .snap     (snap_val)
    );

    always_comb begin
        src_val = (held && !is_lane0) ? snap_val : vis_val;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = src_val[g*8 +: 8];
    end

    always_comb begin
        rd_byte = in_timer ? lane_b[lane_sel] : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_hit   <= 1'b0;
            io_rdata <= 8'h00;
        end else begin
            io_hit   <= rd_hit;
            io_rdata <= rd_hit ? rd_byte : 8'h00;
        end
    end
endmodule

// File: rtl/pm_timer_chk.sv
module pm_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             io_rd,
    input logic             io_hit,
    input logic [7:0]       io_rdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic             win_en,
    input logic [7:0]       win_base
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

    // R10
    hit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> $past(io_rd));

    // R3
    hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> ($past(win_en) && ($past(win_base) != 8'h00)));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> io_rdata == 8'h00);
endmodule

bind pm_timer_top pm_timer_chk #(.CNT_W(CNT_W)) u_pm_timer_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .io_rd    (io_rd),
    .io_hit   (io_hit),
    .io_rdata (io_rdata),
    .cnt_q    (cnt_q),
    .win_en   (win_en),
    .win_base (win_base)
);

// File: tb/test_pm_timer_top.sv
module test_pm_timer_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NARROW_W   = 8;
    localparam int LANES      = CNT_W / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [15:0] io_addr = 16'h0000;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_hit;

    int n_chk = 0;
    int n_fail = 0;

    pm_timer_top #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) i_pm_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_rdata  (io_rdata),
        .io_hit    (io_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    longint m_cnt = 0, m_snap = 0, vis;
    bit     m_en = 0, m_wide = 0, m_held = 0;
    int     m_base = 0, off, ln;
    bit     e_hit = 0;
    int     e_data = 0;
    string  e_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_snap = 0; m_en = 0; m_wide = 0; m_held = 0;
            m_base = 0; e_hit = 0; e_data = 0; e_tag = "R1";
        end else begin
            vis = m_wide ? m_cnt : (m_cnt % (64'd1 << NARROW_W));
            e_hit = 0; e_data = 0; e_tag = "R10";
            if (io_rd && m_en && m_base != 0 && int'(io_addr[15:8]) == m_base) begin
                e_hit = 1;
                off = int'(io_addr[7:0]);
                if (off >= 8 && off < 8 + LANES) begin
                    ln = off - 8;
                    if (ln == 0) begin
                        e_data = int'(vis & 255); m_snap = vis; m_held = 1; e_tag = "R4";
                    end else if (m_held) begin
                        e_data = int'((m_snap >> (8*ln)) & 255); e_tag = "R9";
                        if (ln == LANES - 1) m_held = 0;
                    end else begin
                        e_data = int'((vis >> (8*ln)) & 255);
                        e_tag = m_wide ? "R6" : "R5";
                    end
                end else begin
                    e_data = 255; e_tag = "R7";
                end
            end else if (io_rd) begin
                e_tag = "R3";
            end
            if (cfg_we && cfg_addr == 8'h41) begin m_en = cfg_wdata[7]; m_wide = cfg_wdata[3]; end
            if (cfg_we && cfg_addr == 8'h49) m_base = int'(cfg_wdata);
            if (tick_en) m_cnt = (m_cnt + 1) % (64'd1 << CNT_W);
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (io_hit !== e_hit || int'(io_rdata) != e_data) begin
                n_fail++;
                $display("FAIL %s model: actual hit=%0b data=%02h expected hit=%0b data=%02h",
                         e_tag, io_hit, io_rdata, e_hit, e_data);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output int d, output int h);
        @(negedge clk); io_rd = 1'b1; io_addr = a;
        @(negedge clk); io_rd = 1'b0;
        d = int'(io_rdata); h = int'(io_hit);
        @(negedge clk);
        check("R10 hit drops", int'(io_hit), 0);
    endtask

    initial begin
        int d, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: closed window after reset
        rd(16'h0008, d, h); check("R1 no hit", h, 0);
        cfg(8'h49, 8'h12);
        cfg(8'h41, 8'h88);
        // R11: config visible on the next read; R1 count zero
        rd(16'h1208, d, h); check("R11 hit", h, 1); check("R1 count", d, 8'h00);

        ticks(300);  // 0x012C, R2
        rd(16'h1208, d, h); check("R4 lane0", d, 8'h2C);
        rd(16'h1209, d, h); check("R6 lane1", d, 8'h01);

        cfg(8'h41, 8'h80);
        rd(16'h1208, d, h); check("R5 lane0", d, 8'h2C);
        rd(16'h1209, d, h); check("R5 lane1", d, 8'h00);

        rd(16'h120A, d, h); check("R7 0A", d, 8'hFF);
        rd(16'h1200, d, h); check("R7 00", d, 8'hFF);
        rd(16'h12FF, d, h); check("R7 FF", d, 8'hFF);
        rd(16'h1308, d, h); check("R3 other page", h, 0);

        cfg(8'h40, 8'hFF);
        cfg(8'h48, 8'h00);
        rd(16'h1208, d, h); check("R8 hit", h, 1); check("R8 data", d, 8'h2C);

        cfg(8'h41, 8'h08);
        rd(16'h1208, d, h); check("R3 disabled", h, 0);
        cfg(8'h41, 8'h88);
        cfg(8'h49, 8'h00);
        rd(16'h0008, d, h); check("R3 zero base", h, 0);
        cfg(8'h49, 8'h12);

        // R9 snapshot
        rd(16'h1208, d, h); check("R9 lane0", d, 8'h2C);
        ticks(300);  // 600 = 0x0258
        rd(16'h1209, d, h); check("R9 snap lane1", d, 8'h01);
        rd(16'h1209, d, h); check("R9 released lane1", d, 8'h02);

        // R2 wrap
        ticks(1 << CNT_W);
        rd(16'h1208, d, h); check("R2 wrap lane0", d, 8'h58);
        rd(16'h1209, d, h); check("R2 wrap lane1", d, 8'h02);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule